// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a data cache and keeps the single reservation that load-linked and store-conditional need. A load-linked records its address and arms the reservation. Three things drop it: a coherence invalidation from the snoop side for the cache block that holds that address, a plain store from the local core to the same word, or any store-conditional.

When a store-conditional arrives, the block decides in the same cycle whether it succeeds. It makes that decision from the registered reservation and the address of the store-conditional. The result gates the memory write. It is also returned as the 1 or 0 value that the pipeline writes to the destination register.

The memory stage presents at most one of three strobes per cycle: load-linked, store-conditional or plain store. All three share one address bus. The snoop side presents an invalidation strobe with its own address.

Top module: `resv_monitor`

## Requirements
- R1: After a load-linked with no same-block snoop in its cycle, a store-conditional to the same word raises `sc_ok` in its own cycle.
- R2: Address matching ignores byte offset bits [1:0]. A store-conditional to another byte of the linked word succeeds. One to a different word fails.
- R3: After reset, with no load-linked seen, a store-conditional fails.
- R4: Every store-conditional drops the reservation, whether it succeeds or fails. A following store-conditional to the same word fails.
- R5: A snoop invalidation whose block address (bits above `BLK_OFS`, default 3, so 8-byte blocks) equals the linked block drops the reservation. A snoop to another block leaves it armed.
- R6: A plain local store to the linked word drops the reservation. A store to another word of the same block leaves it armed.
- R7: A snoop invalidation to the block of a load-linked, arriving in the same cycle, leaves the reservation disarmed.
- R8: `st_commit` equals `sc_ok` during a store-conditional. It is 1 during a plain store and 0 otherwise.
- R9: `rd_result` is 1 when a store-conditional succeeds and 0 on failure or when no store-conditional is present.
- R10: A new load-linked replaces the earlier linked address. A store-conditional to the old address then fails.
- R11: A snoop arriving in the same cycle as a store-conditional does not change that store-conditional's outcome.
- R12: `sc_ok` is high only while `sc_req` is high.
- R13: At most one of `ll_req`, `sc_req` and `st_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ll_req | input | 1 | Load-linked in the memory stage |
| sc_req | input | 1 | Store-conditional in the memory stage |
| st_req | input | 1 | Plain store in the memory stage |
| req_addr | input | ADDR_W | Byte address of the memory-stage access |
| snoop_inv | input | 1 | Coherence invalidation for this cache |
| snoop_addr | input | ADDR_W | Byte address of the invalidated block |
| sc_ok | output | 1 | Store-conditional succeeds (combinational) |
| st_commit | output | 1 | Store write enable toward the cache |
| rd_result | output | DATA_W | Value for the store-conditional's destination register |

## Verification
All three outputs are combinational in the memory-stage cycle of the request. The bench therefore drives each vector at a falling edge and compares the outputs 2 ns later, before the next rising edge.

Each effect on the reservation is registered at the rising edge that ends the request's cycle. It is seen only through the outcome of the next store-conditional, which the vector table places one or more cycles later. The directed reset test arms a reservation, holds reset for one edge, and then checks that a store-conditional fails.

// File: rtl/resv_pkg.sv
// Shared types and helpers for the reservation monitor.
// Assumes address widths of at least 4 bits.
package resv_pkg;

    // What the link register does at the next edge.
    typedef enum logic [1:0] {
        RV_KEEP = 2'd0,
        RV_ARM  = 2'd1,
        RV_DROP = 2'd2
    } resv_act_t;

    // Mask that keeps the bits at and above lsb of a w-bit address.
    function automatic logic [63:0] upper_mask(input int w, input int lsb);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i >= lsb && i < w) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/resv_addr_cmp.sv
// Equality compare of two addresses above a chosen bit.
// Reads every bit, so unused low bits cause no lint warnings.
// Assumes LSB < ADDR_W.
module resv_addr_cmp #(
    parameter int ADDR_W = 32,
    parameter int LSB    = 2
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    output logic              eq
);
    localparam logic [63:0]       MASK_W = resv_pkg::upper_mask(ADDR_W, LSB);
    localparam logic [ADDR_W-1:0] MASK   = MASK_W[ADDR_W-1:0];

    // Equality on the masked difference.
    always_comb eq = (((a ^ b) & MASK) == '0);
endmodule

// File: rtl/resv_link_reg.sv
// Holds the linked address and its valid bit.
// Arm loads the address and the supplied valid value. Drop clears valid.
// Synchronous active-low reset clears valid.
module resv_link_reg #(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  resv_pkg::resv_act_t act,
    input  logic [ADDR_W-1:0]   arm_addr,
    input  logic                arm_valid,
    output logic [ADDR_W-1:0]   link_addr,
    output logic                link_valid
);
    // Address and valid update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_addr  <= '0;
            link_valid <= 1'b0;
        end else begin
            case (act)
                resv_pkg::RV_ARM: begin
                    link_addr  <= arm_addr;
                    link_valid <= arm_valid;
                end
                resv_pkg::RV_DROP: link_valid <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/resv_next_ctl.sv
// Chooses the link register action from the strobes and compare results.
// Priority: a load-linked arms, a snoop hit on its own block vetoes that
// arm, and a store-conditional, a matching store or a snoop hit drops.
module resv_next_ctl (
    input  logic                ll_req,
    input  logic                sc_req,
    input  logic                st_req,
    input  logic                snoop_inv,
    input  logic                st_word_hit,
    input  logic                snoop_link_hit,
    input  logic                snoop_req_hit,
    output resv_pkg::resv_act_t act,
    output logic                arm_valid
);
    // Next action select.
    always_comb begin
        arm_valid = !(snoop_inv && snoop_req_hit);
        if (ll_req)
            act = resv_pkg::RV_ARM;
        else if (sc_req || (st_req && st_word_hit) || (snoop_inv && snoop_link_hit))
            act = resv_pkg::RV_DROP;
        else
            act = resv_pkg::RV_KEEP;
    end
endmodule

// File: rtl/resv_monitor.sv
// Reservation monitor for load-linked / store-conditional.
// Success is decided combinationally from registered state, so a snoop in
// the same cycle as a store-conditional cannot affect that outcome.
// Assumes one-hot-or-none memory strobes.
module resv_monitor #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BLK_OFS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_req,
    input  logic              sc_req,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snoop_inv,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              sc_ok,
    output logic              st_commit,
    output logic [DATA_W-1:0] rd_result
);
    localparam int WORD_OFS = 2;

    resv_pkg::resv_act_t act;
    logic [ADDR_W-1:0]   link_addr;
    logic                link_valid;
    logic                arm_valid;
    logic                req_word_hit;
    logic                snoop_link_hit;
    logic                snoop_req_hit;

    resv_addr_cmp #(.ADDR_W(ADDR_W), .LSB(WORD_OFS)) u_cmp_req (
        .a(req_addr), .b(link_addr), .eq(req_word_hit)
    );

    resv_addr_cmp #(.ADDR_W(ADDR_W), .LSB(BLK_OFS)) u_cmp_snp (
        .a(snoop_addr), .b(link_addr), .eq(snoop_link_hit)
    );

    resv_addr_cmp #(.ADDR_W(ADDR_W), .LSB(BLK_OFS)) u_cmp_new (
        .a(snoop_addr), .b(req_addr), .eq(snoop_req_hit)
    );

    resv_next_ctl u_ctl (
        .ll_req(ll_req), .sc_req(sc_req), .st_req(st_req),
        .snoop_inv(snoop_inv), .st_word_hit(req_word_hit),
        .snoop_link_hit(snoop_link_hit), .snoop_req_hit(snoop_req_hit),
        .act(act), .arm_valid(arm_valid)
    );

    resv_link_reg #(.ADDR_W(ADDR_W)) u_link (
        .clk(clk), .rst_n(rst_n), .act(act), .arm_addr(req_addr),
        .arm_valid(arm_valid), .link_addr(link_addr), .link_valid(link_valid)
    );

    // Success decision, store gate and destination value.
    always_comb begin
        sc_ok     = sc_req && link_valid && req_word_hit;
        st_commit = st_req || sc_ok;
        rd_result = '0;
        rd_result[0] = sc_ok;
    end
endmodule

// File: rtl/resv_monitor_chk.sv
// Property checker for resv_monitor, attached with bind.
module resv_monitor_chk #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BLK_OFS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ll_req,
    input logic              sc_req,
    input logic              st_req,
    input logic [ADDR_W-1:0] req_addr,
    input logic              snoop_inv,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              sc_ok,
    input logic              st_commit,
    input logic [DATA_W-1:0] rd_result
);
    localparam logic [63:0]       WM64 = resv_pkg::upper_mask(ADDR_W, 2);
    localparam logic [63:0]       BM64 = resv_pkg::upper_mask(ADDR_W, BLK_OFS);
    localparam logic [ADDR_W-1:0] WMASK = WM64[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] BMASK = BM64[ADDR_W-1:0];

    assert_strobe_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ll_req, sc_req, st_req}));

    assert_ok_only_in_sc_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> sc_req);

    assert_gate_follows_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |-> (st_commit == sc_ok));

    assert_idle_result_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req |-> (rd_result == '0));

    assert_sc_consumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> !sc_ok);

    assert_ll_then_sc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ll_req && !snoop_inv) && sc_req &&
         ((req_addr & WMASK) == ($past(req_addr) & WMASK))) |-> sc_ok);

    assert_ll_snoop_race_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ll_req && snoop_inv && ((snoop_addr & BMASK) == (req_addr & BMASK)))
        |-> !sc_ok);
endmodule

bind resv_monitor resv_monitor_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_OFS(BLK_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .sc_req(sc_req),
    .st_req(st_req), .req_addr(req_addr), .snoop_inv(snoop_inv),
    .snoop_addr(snoop_addr), .sc_ok(sc_ok), .st_commit(st_commit),
    .rd_result(rd_result)
);

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;
    localparam int N = 29;
    // {op[1:0] (0 idle,1 LL,2 SC,3 ST), addr, snoop, snoop_addr, exp_ok, exp_commit}
    localparam logic [68:0] VEC [N] = '{
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 0  R3 no link
        {2'd1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 1  LL
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b1, 1'b1}, // 2  R1
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 3  R4
        {2'd1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 4
        {2'd2, 32'h102, 1'b0, 32'h0,   1'b1, 1'b1}, // 5  R2 byte offset
        {2'd1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 6
        {2'd2, 32'h104, 1'b0, 32'h0,   1'b0, 1'b0}, // 7  R2 other word
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 8  R4 failed SC drops
        {2'd1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 9
        {2'd0, 32'h0,   1'b1, 32'h108, 1'b0, 1'b0}, // 10 R5 other block
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b1, 1'b1}, // 11 R5
        {2'd1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 12
        {2'd0, 32'h0,   1'b1, 32'h104, 1'b0, 1'b0}, // 13 R5 same block
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 14 R5
        {2'd1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 15
        {2'd3, 32'h104, 1'b0, 32'h0,   1'b0, 1'b1}, // 16 R6 R8 store
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b1, 1'b1}, // 17 R6
        {2'd1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 18
        {2'd3, 32'h101, 1'b0, 32'h0,   1'b0, 1'b1}, // 19 R6 same word
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 20 R6
        {2'd1, 32'h100, 1'b1, 32'h100, 1'b0, 1'b0}, // 21 R7
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 22 R7
        {2'd1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 23
        {2'd1, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0}, // 24 R10
        {2'd2, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0}, // 25 R10
        {2'd1, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0}, // 26
        {2'd2, 32'h200, 1'b1, 32'h200, 1'b1, 1'b1}, // 27 R11
        {2'd2, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0}  // 28 R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ll_req = 1'b0, sc_req = 1'b0, st_req = 1'b0, snoop_inv = 1'b0;
    logic [31:0] req_addr = '0, snoop_addr = '0;
    logic        sc_ok, st_commit;
    logic [31:0] rd_result;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    resv_monitor dut (
        .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .sc_req(sc_req),
        .st_req(st_req), .req_addr(req_addr), .snoop_inv(snoop_inv),
        .snoop_addr(snoop_addr), .sc_ok(sc_ok), .st_commit(st_commit),
        .rd_result(rd_result)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [31:0] a,
                         input logic sn, input logic [31:0] sa);
        @(negedge clk);
        ll_req = (op == 2'd1); sc_req = (op == 2'd2); st_req = (op == 2'd3);
        req_addr = a; snoop_inv = sn; snoop_addr = sa;
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        #2;
        chk("R3 reset sc_ok", {31'b0, sc_ok}, 32'd0);
        chk("R8 reset st_commit", {31'b0, st_commit}, 32'd0);
        chk("R9 reset rd_result", rd_result, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            drive(VEC[i][68:67], VEC[i][66:35], VEC[i][34], VEC[i][33:2]);
            chk($sformatf("R1-table vec%0d sc_ok", i), {31'b0, sc_ok}, {31'b0, VEC[i][1]});
            chk($sformatf("R8 vec%0d st_commit", i), {31'b0, st_commit}, {31'b0, VEC[i][0]});
            chk($sformatf("R9 vec%0d rd_result", i), rd_result, {31'b0, VEC[i][1]});
        end
        // R3: reset drops an armed reservation
        drive(2'd1, 32'h300, 1'b0, 32'h0);
        drive(2'd0, 32'h0, 1'b0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        drive(2'd2, 32'h300, 1'b0, 32'h0);
        chk("R3 sc after reset", {31'b0, sc_ok}, 32'd0);
        // R12: no success without sc_req while armed
        drive(2'd1, 32'h400, 1'b0, 32'h0);
        drive(2'd0, 32'h400, 1'b0, 32'h0);
        chk("R12 idle sc_ok", {31'b0, sc_ok}, 32'd0);
        chk("R8 idle commit", {31'b0, st_commit}, 32'd0);
        drive(2'd2, 32'h400, 1'b0, 32'h0);
        chk("R1 sc after idle gap", {31'b0, sc_ok}, 32'd1);
        drive(2'd0, 32'h0, 1'b0, 32'h0);
        finish_run();
    end
endmodule